// File: doc/BRIEF.md
# SDRAM Command Scheduler

This block turns queued memory requests into DDR SDRAM command cycles. It reads from the read port of a first-word-fall-through request queue. Each request word holds a 3-bit command code above a packed address. The block tracks the single bank and row that is currently open. When a request needs a different row, the block adds a precharge and an activate ahead of the access. It holds back reads and writes until the turnaround gap between the two directions has passed.

A one-cycle refresh-due pulse is latched and held pending. While a refresh is pending, it wins over the next queued request: the scheduler closes any open row, issues an auto refresh, and waits out the refresh recovery time. Requests may also name the maintenance commands directly: mode load, refresh, precharge all and activate. Nothing is taken from the queue until the init-done input is high. The command bus (row strobe, column strobe, write enable, address and bank) comes from a register stage, so every command appears one cycle after the scheduler decides on it.

Top module: `sdram_cmd_sched`

## Requirements
- R1: The bus encodes commands as {ras_n, cas_n, we_n}: mode load 000, refresh 001, precharge 010, activate 011, write 100, read 101, idle 111. The idle code is driven from reset and on every cycle without a command. Out of reset cke_o is high and cs_n_o is low.
- R2: A request word carries its code in bits [34:32]: 000 mode load, 001 refresh, 010 precharge all, 011 activate, 100 write, 101 read, 110 and 111 no operation. Below the code, from bit 0 upward, sit the column (COL_W bits), the row (ROW_W bits), the bank (BANK_W bits), and the chip-select bits up to bit 31. req_pop_o is asserted only while req_empty_i is low.
- R3: While init_done_i is low, no request is popped and no command is issued.
- R4: A read or write with no row open gets an activate of its row and bank first. The access follows at least T_RCD cycles after the activate.
- R5: A read or write whose bank, row and chip-select bits match the open row goes out directly, with no precharge or activate.
- R6: A read or write to a different bank, row or chip-select value first gets a single-bank precharge of the open bank, with A10 low and the other address bits zero. The activate follows at least T_RP cycles after that precharge.
- R7: A read or write drives the column on the address bus: column bits 0 to 9 on A0 to A9, higher column bits from A11 upward, and A10 always low.
- R8: A read comes at least T_WTR cycles after the last write. A write comes at least T_RTW cycles after the last read.
- R9: A pending refresh is served before any queued request. If a row is open, the refresh is preceded by an all-bank precharge (A10 high, bank 0). No command follows a refresh for T_RFC cycles.
- R10: The maintenance codes work as follows.
  - Precharge all issues an all-bank precharge.
  - Mode load issues a mode load. Its address is the low ROW_W bits of the request and its bank is the bank field. If a row is open, an all-bank precharge comes first.
  - Activate opens the named row. If a row is open, a single-bank precharge comes first.
  - Refresh issues a refresh.
  - The no-operation codes are consumed and issue nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Memory initialization complete |
| refresh_due_i | input | 1 | One-cycle refresh request pulse |
| req_empty_i | input | 1 | Request queue empty |
| req_data_i | input | CMD_LSB+3 | Head of request queue (first-word-fall-through) |
| req_pop_o | output | 1 | Consume head of request queue |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ROW_W | Address bus |
| ba_o | output | BANK_W | Bank address |

## Verification
The bench targets three kinds of request.
- Same-bank, different-row requests and different-bank requests: a design that skipped the conflict precharge, or used the all-bank form for it, would issue a wrong or missing precharge.
- A write straight after a read, and a read straight after a write, to the open row: a design that ignored the turnaround would issue the second access too early, which the gap check reports.
- A refresh raised while a conflicting access is under way, with another request already queued: a scheduler without refresh priority would serve the request first.

Mode load, no-operation and activate codes are sent with a row open. This shows the all-bank close, and that no-operation requests leave the bus idle.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    BUS_MRS = 3'b000,
    BUS_REF = 3'b001,
    BUS_PRE = 3'b010,
    BUS_ACT = 3'b011,
    BUS_WR  = 3'b100,
    BUS_RD  = 3'b101,
    BUS_NOP = 3'b111
  } bus_cmd_e;

  localparam logic [2:0] UC_LMR  = 3'b000;
  localparam logic [2:0] UC_REF  = 3'b001;
  localparam logic [2:0] UC_PREA = 3'b010;
  localparam logic [2:0] UC_ACT  = 3'b011;
  localparam logic [2:0] UC_WR   = 3'b100;
  localparam logic [2:0] UC_RD   = 3'b101;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ACT, S_ACC, S_REF, S_MRS
  } state_e;

  localparam int AP_BIT = 10;
endpackage

// File: rtl/sched_timer.sv
module sched_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sched_req_decode.sv
module sched_req_decode #(
  parameter int COL_W   = 10,
  parameter int ROW_W   = 13,
  parameter int BANK_W  = 2,
  parameter int CMD_LSB = 32,
  localparam int RANK_W = CMD_LSB - COL_W - ROW_W - BANK_W
) (
  input  logic [CMD_LSB+2:0] req_i,
  output logic [2:0]         cmd_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [RANK_W-1:0]  rank_o,
  output logic [ROW_W-1:0]   col_addr_o,
  output logic [ROW_W-1:0]   mode_o
);
  import sched_pkg::*;

  logic [COL_W-1:0] col;

  assign col    = req_i[COL_W-1:0];
  assign row_o  = req_i[COL_W +: ROW_W];
  assign bank_o = req_i[COL_W+ROW_W +: BANK_W];
  assign rank_o = req_i[COL_W+ROW_W+BANK_W +: RANK_W];
  assign cmd_o  = req_i[CMD_LSB +: 3];
  assign mode_o = req_i[ROW_W-1:0];

  // column bits skip the auto-precharge position
  for (genvar i = 0; i < ROW_W; i++) begin : g_col
    if (i < AP_BIT) begin : g_lo
      if (i < COL_W) begin : g_on
        assign col_addr_o[i] = col[i];
      end else begin : g_off
        assign col_addr_o[i] = 1'b0;
      end
    end else if (i == AP_BIT) begin : g_ap
      assign col_addr_o[i] = 1'b0;
    end else begin : g_hi
      if (i - 1 < COL_W) begin : g_on
        assign col_addr_o[i] = col[i-1];
      end else begin : g_off
        assign col_addr_o[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/sched_cmd_out.sv
module sched_cmd_out
  import sched_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_cmd_e          cmd_i,
  input  logic [ROW_W-1:0]  addr_i,
  input  logic [BANK_W-1:0] ba_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o  <= 1'b0;
      cs_n_o <= 1'b1;
      {ras_n_o, cas_n_o, we_n_o} <= BUS_NOP;
      addr_o <= '0;
      ba_o   <= '0;
    end else begin
      cke_o  <= 1'b1;
      cs_n_o <= 1'b0;
      {ras_n_o, cas_n_o, we_n_o} <= cmd_i;
      addr_o <= addr_i;
      ba_o   <= ba_i;
    end
  end
endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched
  import sched_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int ROW_W   = 13,
  parameter int BANK_W  = 2,
  parameter int CMD_LSB = 32,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 3,
  parameter int T_RFC   = 8,
  parameter int T_WTR   = 4,
  parameter int T_RTW   = 5,
  parameter int T_MRD   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_done_i,
  input  logic               refresh_due_i,
  input  logic               req_empty_i,
  input  logic [CMD_LSB+2:0] req_data_i,
  output logic               req_pop_o,
  output logic               cke_o,
  output logic               cs_n_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic               we_n_o,
  output logic [ROW_W-1:0]   addr_o,
  output logic [BANK_W-1:0]  ba_o
);
  localparam int RANK_W = CMD_LSB - COL_W - ROW_W - BANK_W;
  localparam int TW = $clog2(T_RP + T_RCD + T_RFC + T_WTR + T_RTW + T_MRD + 2);
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1 << AP_BIT);

  logic [2:0]        dec_cmd;
  logic [ROW_W-1:0]  dec_row, dec_col, dec_mode;
  logic [BANK_W-1:0] dec_bank;
  logic [RANK_W-1:0] dec_rank;

  sched_req_decode #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .CMD_LSB(CMD_LSB)
  ) u_dec (
    .req_i(req_data_i), .cmd_o(dec_cmd), .row_o(dec_row), .bank_o(dec_bank),
    .rank_o(dec_rank), .col_addr_o(dec_col), .mode_o(dec_mode)
  );

  state_e            state_q, state_d, after_pre_q, after_pre_d;
  logic              pre_all_q, pre_all_d;
  logic              open_q;
  logic [ROW_W-1:0]  open_row_q, row_q, col_q, mode_q;
  logic [BANK_W-1:0] open_bank_q, bank_q;
  logic [RANK_W-1:0] open_rank_q, rank_q;
  logic              is_wr_q, acc_q, last_wr_q, ref_pend_q;
  logic              hit, pop;
  bus_cmd_e          iss_cmd;
  logic [ROW_W-1:0]  iss_addr;
  logic [BANK_W-1:0] iss_ba;
  logic              wait_ld, turn_ld, wait_zero, turn_zero;
  logic [TW-1:0]     wait_val, turn_val;

  sched_timer #(.W(TW)) u_wait (
    .clk_i, .rst_ni, .load_i(wait_ld), .val_i(wait_val), .zero_o(wait_zero)
  );
  sched_timer #(.W(TW)) u_turn (
    .clk_i, .rst_ni, .load_i(turn_ld), .val_i(turn_val), .zero_o(turn_zero)
  );

  assign hit = open_q && (dec_bank == open_bank_q) && (dec_row == open_row_q)
               && (dec_rank == open_rank_q);

  always_comb begin
    state_d     = state_q;
    after_pre_d = after_pre_q;
    pre_all_d   = pre_all_q;
    pop      = 1'b0;
    iss_cmd  = BUS_NOP;
    iss_addr = '0;
    iss_ba   = '0;
    wait_ld  = 1'b0;
    wait_val = '0;
    turn_ld  = 1'b0;
    turn_val = '0;
    unique case (state_q)
      S_IDLE: if (init_done_i) begin
        if (ref_pend_q) begin
          pre_all_d = 1'b1; after_pre_d = S_REF;
          state_d = open_q ? S_PRE : S_REF;
        end else if (!req_empty_i) begin
          pop = 1'b1;
          case (dec_cmd)
            UC_LMR: begin
              pre_all_d = 1'b1; after_pre_d = S_MRS;
              state_d = open_q ? S_PRE : S_MRS;
            end
            UC_REF: begin
              pre_all_d = 1'b1; after_pre_d = S_REF;
              state_d = open_q ? S_PRE : S_REF;
            end
            UC_PREA: begin
              pre_all_d = 1'b1; after_pre_d = S_IDLE; state_d = S_PRE;
            end
            UC_ACT: begin
              pre_all_d = 1'b0; after_pre_d = S_ACT;
              state_d = open_q ? S_PRE : S_ACT;
            end
            UC_WR, UC_RD: begin
              pre_all_d = 1'b0; after_pre_d = S_ACT;
              state_d = hit ? S_ACC : (open_q ? S_PRE : S_ACT);
            end
            default: ;
          endcase
        end
      end
      S_PRE: if (wait_zero) begin
        iss_cmd  = BUS_PRE;
        iss_addr = pre_all_q ? AP_MASK : '0;
        iss_ba   = pre_all_q ? '0 : open_bank_q;
        wait_ld = 1'b1; wait_val = TW'(T_RP - 1);
        state_d = after_pre_q;
      end
      S_ACT: if (wait_zero) begin
        iss_cmd = BUS_ACT; iss_addr = row_q; iss_ba = bank_q;
        wait_ld = 1'b1; wait_val = TW'(T_RCD - 1);
        state_d = acc_q ? S_ACC : S_IDLE;
      end
      S_ACC: if (wait_zero && (turn_zero || (last_wr_q == is_wr_q))) begin
        iss_cmd = is_wr_q ? BUS_WR : BUS_RD; iss_addr = col_q; iss_ba = bank_q;
        wait_ld = 1'b1;
        turn_ld = 1'b1; turn_val = is_wr_q ? TW'(T_WTR - 1) : TW'(T_RTW - 1);
        state_d = S_IDLE;
      end
      S_REF: if (wait_zero) begin
        iss_cmd = BUS_REF;
        wait_ld = 1'b1; wait_val = TW'(T_RFC - 1);
        state_d = S_IDLE;
      end
      S_MRS: if (wait_zero) begin
        iss_cmd = BUS_MRS; iss_addr = mode_q; iss_ba = bank_q;
        wait_ld = 1'b1; wait_val = TW'(T_MRD - 1);
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; after_pre_q <= S_IDLE; pre_all_q <= 1'b0;
      open_q <= 1'b0; open_row_q <= '0; open_bank_q <= '0; open_rank_q <= '0;
      row_q <= '0; col_q <= '0; mode_q <= '0; bank_q <= '0; rank_q <= '0;
      is_wr_q <= 1'b0; acc_q <= 1'b0; last_wr_q <= 1'b0; ref_pend_q <= 1'b0;
    end else begin
      state_q <= state_d; after_pre_q <= after_pre_d; pre_all_q <= pre_all_d;
      if (pop) begin
        row_q <= dec_row; col_q <= dec_col; mode_q <= dec_mode;
        bank_q <= dec_bank; rank_q <= dec_rank;
        is_wr_q <= (dec_cmd == UC_WR);
        acc_q   <= (dec_cmd == UC_WR) || (dec_cmd == UC_RD);
      end
      if (iss_cmd == BUS_PRE) open_q <= 1'b0;
      if (iss_cmd == BUS_ACT) begin
        open_q <= 1'b1; open_row_q <= row_q; open_bank_q <= bank_q;
        open_rank_q <= rank_q;
      end
      if (iss_cmd == BUS_WR) last_wr_q <= 1'b1;
      if (iss_cmd == BUS_RD) last_wr_q <= 1'b0;
      if (iss_cmd == BUS_REF) ref_pend_q <= 1'b0;
      if (refresh_due_i)      ref_pend_q <= 1'b1;
    end
  end

  assign req_pop_o = pop;

  sched_cmd_out #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_out (
    .clk_i, .rst_ni, .cmd_i(iss_cmd), .addr_i(iss_addr), .ba_i(iss_ba),
    .cke_o, .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .addr_o, .ba_o
  );
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int ROW_W = 13,
  parameter int T_RP  = 3,
  parameter int T_RCD = 3,
  parameter int T_RFC = 8,
  parameter int T_WTR = 4,
  parameter int T_RTW = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_done_i,
  input logic             req_empty_i,
  input logic             req_pop_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic [ROW_W-1:0] addr_o
);
  logic [2:0] bus;
  logic is_act, is_pre, is_ref, is_wr, is_rd, is_cmd;
  logic [7:0] since_act, since_pre, since_ref, since_wr, since_rd;

  assign bus    = {ras_n_o, cas_n_o, we_n_o};
  assign is_act = (bus == 3'b011);
  assign is_pre = (bus == 3'b010);
  assign is_ref = (bus == 3'b001);
  assign is_wr  = (bus == 3'b100);
  assign is_rd  = (bus == 3'b101);
  assign is_cmd = (bus != 3'b111);

  function automatic logic [7:0] step(input logic ev, input logic [7:0] q);
    if (ev) return 8'd1;
    return (q == 8'hFF) ? q : q + 8'd1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= 8'hFF; since_pre <= 8'hFF; since_ref <= 8'hFF;
      since_wr  <= 8'hFF; since_rd  <= 8'hFF;
    end else begin
      since_act <= step(is_act, since_act);
      since_pre <= step(is_pre, since_pre);
      since_ref <= step(is_ref, since_ref);
      since_wr  <= step(is_wr,  since_wr);
      since_rd  <= step(is_rd,  since_rd);
    end
  end

  p_legal_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus != 3'b110);
  p_pop_nonempty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_pop_o |-> !req_empty_i);
  p_no_pop_pre_init_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |-> !req_pop_o);
  p_no_cmd_pre_init_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |=> !is_cmd);
  p_rcd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd || is_wr) |-> int'(since_act) >= T_RCD);
  p_rp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act || is_ref || bus == 3'b000) |-> int'(since_pre) >= T_RP);
  p_ap_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd || is_wr) |-> !addr_o[10]);
  p_wtr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd |-> int'(since_wr) >= T_WTR);
  p_rtw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |-> int'(since_rd) >= T_RTW);
  p_rfc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmd |-> int'(since_ref) >= T_RFC);
endmodule

bind sdram_cmd_sched sched_checker #(
  .ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
  .T_WTR(T_WTR), .T_RTW(T_RTW)
) u_sched_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_done_i(init_done_i),
  .req_empty_i(req_empty_i), .req_pop_o(req_pop_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o)
);

// File: tb/sdram_cmd_sched_bench.sv
module sdram_cmd_sched_bench;
  localparam int COL_W = 10, ROW_W = 13, BANK_W = 2, CMD_LSB = 32;
  localparam int T_RP = 3, T_RCD = 3, T_RFC = 8, T_WTR = 4, T_RTW = 5, T_MRD = 2;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                         C_ACT = 3'b011, C_WR = 3'b100, C_RD = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_done = 1'b0, refresh_due = 1'b0, req_empty = 1'b1, req_pop;
  logic [CMD_LSB+2:0] req_data = '0;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] addr;
  logic [BANK_W-1:0] ba;

  always #4 clk = ~clk;

  sdram_cmd_sched #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .CMD_LSB(CMD_LSB),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .T_WTR(T_WTR),
    .T_RTW(T_RTW), .T_MRD(T_MRD)
  ) u_sdram_cmd_sched (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done),
    .refresh_due_i(refresh_due), .req_empty_i(req_empty), .req_data_i(req_data),
    .req_pop_o(req_pop), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr), .ba_o(ba)
  );

  typedef struct {
    logic [2:0] cmd;
    logic [ROW_W-1:0] addr;
    logic [BANK_W-1:0] ba;
    int gap;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  logic [CMD_LSB+2:0] req_q[$];
  int checks = 0, fails = 0, cyc = 0, last_cyc = -1000;
  logic pop_last = 1'b0;
  logic mon_on = 1'b0;

  function automatic logic [CMD_LSB+2:0] mk(input logic [2:0] code, input int bank,
                                            input int row, input int col);
    logic [CMD_LSB+2:0] r;
    r = '0;
    r[COL_W-1:0] = COL_W'(col);
    r[COL_W +: ROW_W] = ROW_W'(row);
    r[COL_W+ROW_W +: BANK_W] = BANK_W'(bank);
    r[CMD_LSB +: 3] = code;
    return r;
  endfunction

  task automatic expect_cmd(input logic [2:0] c, input int a, input int b,
                            input int gap, input string tag);
    exp_t e;
    e.cmd = c; e.addr = ROW_W'(a); e.ba = BANK_W'(b); e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send(input logic [CMD_LSB+2:0] r);
    req_q.push_back(r);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // request queue model: first-word-fall-through
  always @(posedge clk) pop_last <= req_pop;
  always @(negedge clk) begin
    if (pop_last && req_q.size() != 0) void'(req_q.pop_front());
    req_empty <= (req_q.size() == 0);
    req_data  <= (req_q.size() != 0) ? req_q[0] : '0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_on && {ras_n, cas_n, we_n} != 3'b111) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected command", int'({ras_n, cas_n, we_n}), 7);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({ras_n, cas_n, we_n} == e.cmd, {e.tag, " cmd"},
              int'({ras_n, cas_n, we_n}), int'(e.cmd));
        check(addr == e.addr && ba == e.ba, {e.tag, " addr/bank"},
              int'({ba, addr}), int'({e.ba, e.addr}));
        check(cyc - last_cyc >= e.gap, {e.tag, " gap"}, cyc - last_cyc, e.gap);
      end
      last_cyc = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    // R1 reset and idle state
    check({ras_n, cas_n, we_n} == 3'b111, "R1 idle code", int'({ras_n, cas_n, we_n}), 7);
    check(cke == 1'b1, "R1 cke", int'(cke), 1);
    check(cs_n == 1'b0, "R1 cs_n", int'(cs_n), 0);
    check(req_pop == 1'b0, "R3 pop at reset", int'(req_pop), 0);

    // R3: nothing happens before init done
    send(mk(C_RD, 1, 5, 8));
    begin
      bit popped = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (req_pop) popped = 1'b1;
      end
      check(!popped, "R3 pop before init", int'(popped), 0);
      check(req_q.size() == 1, "R3 queue held", req_q.size(), 1);
    end

    // R4 closed row, R2 field positions
    expect_cmd(C_ACT, 5, 1, 1, "R4 act");
    expect_cmd(C_RD, 8, 1, T_RCD, "R4 R2 read");
    init_done = 1'b1;
    drain();

    // R5 hit, R7 column mapping, R8 turnaround
    expect_cmd(C_WR, 12'h3FF, 1, T_RTW, "R5 R8 R7 write");
    expect_cmd(C_RD, 4, 1, T_WTR, "R8 read after write");
    expect_cmd(C_RD, 5, 1, 1, "R5 read hit");
    send(mk(C_WR, 1, 5, 10'h3FF));
    send(mk(C_RD, 1, 5, 4));
    send(mk(C_RD, 1, 5, 5));
    drain();

    // R6 row conflict, then bank conflict
    expect_cmd(C_PRE, 0, 1, 1, "R6 single pre");
    expect_cmd(C_ACT, 6, 1, T_RP, "R6 act");
    expect_cmd(C_RD, 1, 1, T_RCD, "R6 read");
    expect_cmd(C_PRE, 0, 1, 1, "R6 bank pre");
    expect_cmd(C_ACT, 6, 2, T_RP, "R6 bank act");
    expect_cmd(C_WR, 2, 2, T_RCD, "R6 write");
    send(mk(C_RD, 1, 6, 1));
    send(mk(C_WR, 2, 6, 2));
    drain();

    // R9 refresh wins over a queued request
    expect_cmd(C_PRE, 0, 2, 1, "R6 pre");
    expect_cmd(C_ACT, 7, 3, T_RP, "R6 act");
    expect_cmd(C_WR, 3, 3, T_RCD, "R6 write");
    expect_cmd(C_PRE, 13'h400, 0, 1, "R9 pre all");
    expect_cmd(C_REF, 0, 0, T_RP, "R9 refresh");
    expect_cmd(C_ACT, 7, 3, T_RFC, "R9 act after refresh");
    expect_cmd(C_RD, 9, 3, T_RCD, "R9 read");
    send(mk(C_WR, 3, 7, 3));
    for (int i = 0; i < 50 && req_q.size() != 0; i++) @(negedge clk);
    refresh_due = 1'b1;
    send(mk(C_RD, 3, 7, 9));
    @(negedge clk);
    refresh_due = 1'b0;
    drain();

    // R10 precharge all; R9 refresh with no row open
    expect_cmd(C_PRE, 13'h400, 0, 1, "R10 pre all");
    send(mk(C_PREA, 0, 0, 0));
    drain();
    expect_cmd(C_REF, 0, 0, T_RP, "R9 refresh closed");
    refresh_due = 1'b1;
    @(negedge clk);
    refresh_due = 1'b0;
    drain();

    // R10 mode load, activate, mode load with row open, no-ops, refresh
    expect_cmd(C_MRS, 12'h062, 1, T_RFC, "R10 mode load");
    expect_cmd(C_ACT, 9, 0, T_MRD, "R10 activate");
    expect_cmd(C_PRE, 13'h400, 0, 1, "R10 pre before mode");
    expect_cmd(C_MRS, 12'h033, 0, T_RP, "R10 mode load open");
    expect_cmd(C_REF, 0, 0, T_MRD, "R10 no-op then refresh");
    send(mk(C_LMR_CODE(), 1, 0, 12'h062));
    send(mk(C_ACT, 0, 9, 0));
    send(mk(C_MRS, 0, 0, 12'h033));
    send(mk(3'b110, 2, 3, 4));
    send(mk(3'b111, 1, 1, 1));
    send(mk(C_REF, 0, 0, 0));
    drain();
    repeat (20) @(negedge clk);

    check(exp_q.size() == 0, "R10 all expected commands seen", exp_q.size(), 0);
    check(req_q.size() == 0, "R10 queue drained", req_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [2:0] C_PREA = 3'b010;
  function automatic logic [2:0] C_LMR_CODE();
    return 3'b000;
  endfunction
endmodule